// File: doc/BRIEF.md
# Quadrature and Pulse Direction Decoder

This block sits in front of a position counter and turns two slow external pulse lines into single-cycle count strobes in the system clock domain. Each line, and nothing else about the encoder, is brought into the clock domain through a synchronizer. Every later decision uses only the sampled values. The block decodes the lines in one of two ways. In phase mode they are a pair of 90-degree shifted tracks, and an edge-evaluation code picks the multiplier (x1, x2 or x4). In pulse mode one line carries up pulses and the other carries down pulses.

A direction pin inverts the sense of counting in both modes. In phase mode a sample in which both tracks change at once cannot be ordered. Such a sample gives no count and raises a one-cycle fault strobe. A counter, the registers behind it and any host access are outside this block.

Top module: `quad_pulse_decoder`

## Requirements
- R1: A change on a pulse input that is set up before clock edge k shows on `up_o`/`dn_o` after edge k+2: two synchronizer stages, then the registered decision.
- R2: While `rst` is high all three outputs are 0. During the first SYNC_STAGES+2 edges after `rst` falls, no strobe is produced, whatever levels the inputs held across reset.
- R3: In phase mode (`mode_i`=0) with `dir_i`=1, the track order A then B, which is the (A,B) state walk 00,10,11,01,00, counts up. The reverse walk counts down.
- R4: The edge code `evsel_i` selects the multiplier. 2'b00 counts only a change of A that is sampled while B is 0. 2'b01 counts every change of A. 2'b11 counts every change of A or B. 2'b10 behaves exactly as 2'b00.
- R5: In phase mode `dir_i`=0 swaps up and down relative to R3.
- R6: In phase mode a sample in which A and B both change gives no count and a `fault_o` pulse that is one cycle wide.
- R7: In pulse mode (`mode_i`=1) with `dir_i`=1, a sampled rising edge on A gives one up strobe and one on B gives one down strobe. `dir_i`=0 swaps them. Falling edges count nothing.
- R8: In pulse mode `fault_o` stays 0, even when both lines change in the same sample.
- R9: `up_o` and `dn_o` are never high in the same cycle. In pulse mode, rising edges on both lines in one sample produce neither strobe.
- R10: Each counted event yields exactly one strobe, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pha_i | input | 1 | Track A, or up-pulse line in pulse mode (asynchronous) |
| phb_i | input | 1 | Track B, or down-pulse line in pulse mode (asynchronous) |
| mode_i | input | 1 | 0: phase-shifted tracks, 1: separate pulse lines |
| dir_i | input | 1 | 1: normal count sense, 0: inverted |
| evsel_i | input | 2 | Edge evaluation: 00 x1, 01 x2, 11 x4, 10 as 00 |
| up_o | output | 1 | One-cycle count-up strobe |
| dn_o | output | 1 | One-cycle count-down strobe |
| fault_o | output | 1 | One-cycle strobe for an abnormal phase sample |

## Verification
Full forward and reverse track cycles are applied under each edge code. The number of strobes per cycle (1, 2 or 4) separates the multipliers and also shows that code 10 folds onto x1. Repeating the same cycles with the direction pin low tells inversion apart from a wrong state walk. A jump from 00 to 11 exercises the abnormal path. In pulse mode, isolated pulses and simultaneous pulses on both lines separate correct line-to-direction mapping from cancellation and from stray faults. A behavioural model keyed on the sample history is compared on every clock, and holding the inputs high across reset exposes spurious start-up strobes.

// File: rtl/qd_pkg.sv
package qd_pkg;

  typedef enum logic [1:0] {
    EV_X1  = 2'b00,
    EV_X2  = 2'b01,
    EV_RSV = 2'b10,
    EV_X4  = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic bad;
  } step_t;

  localparam step_t STEP_NONE = '{up: 1'b0, dn: 1'b0, bad: 1'b0};

endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/qd_phase_dec.sv
module qd_phase_dec
  import qd_pkg::*;
(
  input  logic [1:0] now_s,   // {B, A}
  input  logic [1:0] prv_s,
  input  logic [1:0] evsel,
  input  logic       dir,
  output step_t      step
);

  logic       chg_a, chg_b, fwd, hit;
  edge_mode_e ev;

  always_comb begin
    ev    = edge_mode_e'(evsel);
    chg_a = now_s[0] ^ prv_s[0];
    chg_b = now_s[1] ^ prv_s[1];
    // A lead: after an A change A differs from B, after a B change they agree
    fwd   = chg_a ? (now_s[0] ^ now_s[1]) : ~(now_s[0] ^ now_s[1]);
    unique case (ev)
      EV_X2:   hit = chg_a;
      EV_X4:   hit = chg_a | chg_b;
      default: hit = chg_a & ~now_s[1];
    endcase
    step = STEP_NONE;
    if (chg_a && chg_b) begin
      step.bad = 1'b1;
    end else if (hit) begin
      step.up = fwd ~^ dir;
      step.dn = fwd ^ dir;
    end
  end

endmodule

// File: rtl/qd_pulse_dec.sv
module qd_pulse_dec
  import qd_pkg::*;
(
  input  logic [1:0] now_s,   // {B, A}
  input  logic [1:0] prv_s,
  input  logic       dir,
  output step_t      step
);

  logic [1:0] rise;

  always_comb begin
    rise = now_s & ~prv_s;
    step = STEP_NONE;
    unique case (rise)
      2'b01:   begin step.up = dir;  step.dn = ~dir; end
      2'b10:   begin step.up = ~dir; step.dn = dir;  end
      default: step = STEP_NONE;
    endcase
  end

endmodule

// File: rtl/quad_pulse_decoder.sv
module quad_pulse_decoder
  import qd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pha_i,
  input  logic       phb_i,
  input  logic       mode_i,
  input  logic       dir_i,
  input  logic [1:0] evsel_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       fault_o
);

  localparam int WARM   = SYNC_STAGES + 1;
  localparam int WARM_W = $clog2(WARM + 1);

  logic [1:0]        smp_now;
  logic [1:0]        smp_prv;
  logic [WARM_W-1:0] warm_cnt;
  logic              ready;
  step_t             ph_step, pu_step, sel_step;

  qd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({phb_i, pha_i}),
    .q   (smp_now)
  );

  always_ff @(posedge clk) begin
    if (rst) smp_prv <= '0;
    else     smp_prv <= smp_now;
  end

  // hold decisions off until the history register carries real samples
  always_ff @(posedge clk) begin
    if (rst)                        warm_cnt <= '0;
    else if (warm_cnt != WARM_W'(WARM)) warm_cnt <= warm_cnt + 1'b1;
  end
  assign ready = (warm_cnt == WARM_W'(WARM));

  qd_phase_dec u_phase (
    .now_s (smp_now),
    .prv_s (smp_prv),
    .evsel (evsel_i),
    .dir   (dir_i),
    .step  (ph_step)
  );

  qd_pulse_dec u_pulse (
    .now_s (smp_now),
    .prv_s (smp_prv),
    .dir   (dir_i),
    .step  (pu_step)
  );

  always_comb begin
    if (!ready)      sel_step = STEP_NONE;
    else if (mode_i) sel_step = pu_step;
    else             sel_step = ph_step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_o    <= 1'b0;
      dn_o    <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      up_o    <= sel_step.up;
      dn_o    <= sel_step.dn;
      fault_o <= sel_step.bad;
    end
  end

endmodule

// File: rtl/qd_checker.sv
module qd_checker (
  input logic       clk,
  input logic       rst,
  input logic       mode_i,
  input logic       up_o,
  input logic       dn_o,
  input logic       fault_o,
  input logic [1:0] now_s,
  input logic [1:0] prv_s
);

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(up_o && dn_o)); // R9

  AST_FAULT_NOT_COUNTED: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!up_o && !dn_o)); // R6

  AST_NO_FAULT_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !$past(mode_i)); // R8

  AST_STROBE_NEEDS_MOTION: assert property (@(posedge clk) disable iff (rst)
    (up_o || dn_o || fault_o) |-> $past(now_s != prv_s)); // R10

  AST_FAULT_BOTH_MOVED: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> $past((now_s[0] != prv_s[0]) && (now_s[1] != prv_s[1]))); // R6

endmodule

bind quad_pulse_decoder qd_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode_i  (mode_i),
  .up_o    (up_o),
  .dn_o    (dn_o),
  .fault_o (fault_o),
  .now_s   (smp_now),
  .prv_s   (smp_prv)
);

// File: tb/sim_quad_pulse_decoder.sv
module sim_quad_pulse_decoder;

  localparam int PERIOD = 10;
  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pha = 1'b0, phb = 1'b0, mode = 1'b0, dir = 1'b1;
  logic [1:0] evsel = 2'b11;
  logic up_o, dn_o, fault_o;

  int n_chk = 0, n_err = 0;
  int c_up = 0, c_dn = 0, c_flt = 0, c_both = 0;
  bit done = 1'b0;

  // sample history since reset
  logic qa[$], qb[$];
  bit   e_up, e_dn, e_flt;

  always #(PERIOD/2) clk = ~clk;

  quad_pulse_decoder #(.SYNC_STAGES(STAGES)) u0 (
    .clk(clk), .rst(rst), .pha_i(pha), .phb_i(phb), .mode_i(mode),
    .dir_i(dir), .evsel_i(evsel), .up_o(up_o), .dn_o(dn_o), .fault_o(fault_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int gray_pos(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  // reference model and per-clock comparison
  always begin
    @(posedge clk);
    e_up = 0; e_dn = 0; e_flt = 0;
    if (rst) begin
      qa.delete(); qb.delete();
    end else begin
      int e, step;
      logic a2, b2, a3, b3;
      qa.push_back(pha); qb.push_back(phb);
      e = qa.size();
      if (e >= STAGES + 2) begin
        a2 = qa[e-3]; b2 = qb[e-3]; a3 = qa[e-4]; b3 = qb[e-4];
        if (!mode) begin
          if (a2 != a3 && b2 != b3) e_flt = 1;
          else begin
            bit cnt;
            step = (gray_pos(a2, b2) - gray_pos(a3, b3) + 4) % 4;
            if (evsel == 2'b11)      cnt = (a2 != a3) || (b2 != b3);
            else if (evsel == 2'b01) cnt = (a2 != a3);
            else                     cnt = (a2 != a3) && !b2;
            if (cnt) begin
              if ((step == 1) == dir) e_up = 1; else e_dn = 1;
            end
          end
        end else begin
          bit ra, rb;
          ra = a2 && !a3; rb = b2 && !b3;
          if (ra && !rb) begin if (dir) e_up = 1; else e_dn = 1; end
          if (rb && !ra) begin if (dir) e_dn = 1; else e_up = 1; end
        end
      end
    end
    #(PERIOD/4);
    chk(mode ? "R7" : "R3", up_o, e_up);
    chk(mode ? "R7" : "R3", dn_o, e_dn);
    chk(mode ? "R8" : "R6", fault_o, e_flt);
    c_up += up_o; c_dn += dn_o; c_flt += fault_o;
    if (up_o && dn_o) c_both++;
  end

  task automatic settle_and_clear();
    repeat (8) @(negedge clk);
    c_up = 0; c_dn = 0; c_flt = 0;
  endtask

  task automatic drive(input logic a, input logic b);
    @(negedge clk);
    pha = a; phb = b;
    repeat (3) @(negedge clk);
  endtask

  // one full track cycle starting and ending at 00
  task automatic quad_cycle(input bit forward);
    if (forward) begin drive(1,0); drive(1,1); drive(0,1); drive(0,0); end
    else         begin drive(0,1); drive(1,1); drive(1,0); drive(0,0); end
  endtask

  task automatic pulse_line(input bit on_b);
    drive(on_b ? pha : 1'b1, on_b ? 1'b1 : phb);
    drive(1'b0, 1'b0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL R2 watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R2: outputs low in reset, inputs held high across reset
    pha = 1; phb = 1;
    repeat (3) @(negedge clk);
    chk("R2", up_o | dn_o | fault_o, 0);
    rst = 0;
    repeat (6) @(negedge clk);
    chk("R2", c_up + c_dn + c_flt, 0);
    drive(0, 0);

    // R4: x4 forward, two cycles
    mode = 0; dir = 1; evsel = 2'b11;
    settle_and_clear();
    quad_cycle(1); quad_cycle(1);
    chk("R4", c_up, 8); chk("R3", c_dn, 0);

    evsel = 2'b01; settle_and_clear();
    quad_cycle(1); quad_cycle(1);
    chk("R4", c_up, 4);

    evsel = 2'b00; settle_and_clear();
    quad_cycle(1); quad_cycle(1);
    chk("R4", c_up, 2);

    evsel = 2'b10; settle_and_clear();
    quad_cycle(1); quad_cycle(1);
    chk("R4", c_up, 2);

    // R3: reverse walk counts down
    evsel = 2'b11; settle_and_clear();
    quad_cycle(0); quad_cycle(0);
    chk("R3", c_dn, 8); chk("R3", c_up, 0);

    // R5: direction pin low inverts
    dir = 0; settle_and_clear();
    quad_cycle(1);
    chk("R5", c_dn, 4); chk("R5", c_up, 0);
    evsel = 2'b00; settle_and_clear();
    quad_cycle(0);
    chk("R5", c_up, 1);
    dir = 1; evsel = 2'b11;

    // R6: both tracks jump together
    settle_and_clear();
    drive(1, 1);
    chk("R6", c_flt, 1); chk("R6", c_up + c_dn, 0);
    drive(0, 0);

    // R1 and R10: latency and width of a single strobe
    settle_and_clear();
    @(negedge clk); pha = 1;
    @(posedge clk); #(PERIOD/4); chk("R1", up_o, 0);
    @(posedge clk); #(PERIOD/4); chk("R1", up_o, 0);
    @(posedge clk); #(PERIOD/4); chk("R1", up_o, 1);
    @(posedge clk); #(PERIOD/4); chk("R10", up_o, 0);
    drive(1, 0); drive(0, 0);

    // R7: pulse mode mapping
    mode = 1; dir = 1; settle_and_clear();
    repeat (3) pulse_line(0);
    repeat (2) pulse_line(1);
    chk("R7", c_up, 3); chk("R7", c_dn, 2);
    dir = 0; settle_and_clear();
    repeat (3) pulse_line(0);
    pulse_line(1);
    chk("R7", c_dn, 3); chk("R7", c_up, 1);

    // R8, R9: simultaneous rises cancel without fault
    dir = 1; settle_and_clear();
    drive(1, 1); drive(0, 0); drive(1, 1); drive(0, 0);
    chk("R8", c_flt, 0); chk("R9", c_up + c_dn, 0);
    chk("R9", c_both, 0);

    // R2: mid-run reset clears outputs
    mode = 0; @(negedge clk); pha = 1;
    repeat (3) @(negedge clk);
    rst = 1; @(negedge clk);
    chk("R2", up_o | dn_o | fault_o, 0);
    @(negedge clk); rst = 0;
    repeat (10) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule